// File: doc/BRIEF.md
# Stereo Serial Audio DAC Controller

This block takes a stereo sample pair as two parallel 16-bit words and sends it, one bit at a time, to an external stereo DAC over a single serial data line. It runs entirely on a fast system clock. From that clock it produces the DAC bit clock through an integer divider, and it produces a channel-select (left/right) clock that marks which channel the current bits belong to.

Each stereo frame lasts 32 bit periods. The left word goes out first, then the right word, each most significant bit first. Once per frame the block loads the next pair into its two shift registers and pulses a request line, so the feeder knows that the following pair can be written. Words written between two loads wait in a holding register. If nothing is written, the pair already held is sent again. A synchronous reset silences every output and restarts the frame at the first left bit.

Top module: `stereo_ser_dac`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `dac_bclk`, `dac_lrclk`, `dac_sdata` and `smp_req` are all low after that edge. After release, the frame restarts at bit 0 of the left channel.
- R2: `dac_bclk` stays high for DIV_HALF system cycles, then low for DIV_HALF system cycles. Its first rise comes DIV_HALF cycles after the first edge at which reset is released.
- R3: A frame is 32 bit periods. `dac_lrclk` is 0 during the 16 left bit periods and 1 during the 16 right bit periods, and it changes only in the cycle in which `dac_bclk` falls.
- R4: `dac_sdata` changes only in the cycle in which `dac_bclk` falls, so it is stable at every rising edge of `dac_bclk`.
- R5: Within a frame, the 16 left bits are sent first, then the 16 right bits, each word most significant bit first.
- R6: The pair is loaded into the shift registers at the falling `dac_bclk` that ends bit 31. `smp_req` is high for exactly the one cycle after that load, while `dac_lrclk` is 0. The interval between requests is 64*DIV_HALF cycles, and the first request comes 64*DIV_HALF cycles after reset release.
- R7: A cycle with `smp_valid` high stores `smp_left` and `smp_right`. The last write before a load is the pair that is sent. A write made during a frame does not change the bits of that frame.
- R8: If no write happens between two loads, the previously held pair is sent again.
- R9: A write in the same cycle as a load is the pair that the starting frame carries.
- R10: The holding register resets to zero, so the first frame after reset carries all-zero words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Write strobe for the sample pair |
| smp_left | input | 16 | Left channel word, two's complement |
| smp_right | input | 16 | Right channel word, two's complement |
| dac_bclk | output | 1 | Serial bit clock for the DAC |
| dac_lrclk | output | 1 | Channel select, 0 = left, 1 = right |
| dac_sdata | output | 1 | Serial data, changes on falling `dac_bclk` |
| smp_req | output | 1 | One-cycle request for the next sample pair |

## Verification
Two functions can land on the same clock edge: a sample write from the feeder, and the frame-boundary load of the shift registers. The bench counts exactly one frame's worth of cycles from a request and raises `smp_valid` so that the write is sampled at the load edge itself. It then decodes the serial stream of the frame that starts. The frame must carry the freshly written pair, not the stale one, and the request must still appear in the cycle after that edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int CHANNELS   = 2;
    localparam int FRAME_BITS = CHANNELS * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        sample_t right;
        sample_t left;
    } pair_t;

    function automatic chan_e next_chan(chan_e c);
        return (c == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    endfunction

    function automatic sample_t pick_word(pair_t p, int ch);
        return (ch == 0) ? p.left : p.right;
    endfunction

endpackage

// File: rtl/sdac_bitclk.sv
module sdac_bitclk #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // this edge turns bclk from high to low
    assign fall_tick = wrap & bclk;

endmodule

// File: rtl/sdac_sequencer.sv
module sdac_sequencer
    import sdac_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fall_tick,
    output chan_e phase,
    output logic  shift_l,
    output logic  shift_r,
    output logic  load,
    output logic  new_sample
);
    localparam int SW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(WORD_W - 1);

    logic [SW-1:0] slot;
    logic          half_end;

    assign half_end = (slot == LAST_SLOT);
    assign load     = fall_tick & half_end & (phase == CH_RIGHT);
    assign shift_l  = fall_tick & ~half_end & (phase == CH_LEFT);
    assign shift_r  = fall_tick & ~half_end & (phase == CH_RIGHT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot       <= '0;
            phase      <= CH_LEFT;
            new_sample <= 1'b0;
        end else begin
            new_sample <= load;
            if (fall_tick) begin
                if (half_end) begin
                    slot  <= '0;
                    phase <= next_chan(phase);
                end else begin
                    slot  <= slot + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdac_holdreg.sv
module sdac_holdreg
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  pair_t wr_pair,
    output pair_t next_pair
);
    pair_t hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (wr) begin
            hold <= wr_pair;
        end
    end

    // a write coinciding with the frame load is taken directly
    assign next_pair = wr ? wr_pair : hold;

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  pair_t               load_pair,
    input  logic [CHANNELS-1:0] shift_en,
    output logic [CHANNELS-1:0] msb
);
    genvar ch;
    generate
        for (ch = 0; ch < CHANNELS; ch++) begin : g_chan
            sample_t sr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else if (load) begin
                    sr <= pick_word(load_pair, ch);
                end else if (shift_en[ch]) begin
                    sr <= {sr[SAMPLE_W-2:0], 1'b0};
                end
            end

            assign msb[ch] = sr[SAMPLE_W-1];
        end
    endgenerate

endmodule

// File: rtl/stereo_ser_dac.sv
module stereo_ser_dac
    import sdac_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                dac_bclk,
    output logic                dac_lrclk,
    output logic                dac_sdata,
    output logic                smp_req
);
    logic                fall_tick;
    chan_e               phase;
    logic                shift_l;
    logic                shift_r;
    logic                load;
    pair_t               wr_pair;
    pair_t               next_pair;
    logic [CHANNELS-1:0] msb;

    assign wr_pair.left  = smp_left;
    assign wr_pair.right = smp_right;

    sdac_bitclk #(.DIV_HALF(DIV_HALF)) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .bclk     (dac_bclk),
        .fall_tick(fall_tick)
    );

    sdac_sequencer #(.WORD_W(SAMPLE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fall_tick (fall_tick),
        .phase     (phase),
        .shift_l   (shift_l),
        .shift_r   (shift_r),
        .load      (load),
        .new_sample(smp_req)
    );

    sdac_holdreg u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr       (smp_valid),
        .wr_pair  (wr_pair),
        .next_pair(next_pair)
    );

    sdac_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_pair(next_pair),
        .shift_en ({shift_r, shift_l}),
        .msb      (msb)
    );

    assign dac_lrclk = (phase == CH_RIGHT);
    assign dac_sdata = (phase == CH_RIGHT) ? msb[1] : msb[0];

endmodule

// File: rtl/stereo_ser_dac_chk.sv
module stereo_ser_dac_chk #(
    parameter int DIV_HALF = 4
) (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic lrclk,
    input logic sdata,
    input logic req
);
    localparam int FRAME_CYC = 64 * DIV_HALF;
    localparam int RW = $clog2(DIV_HALF + 2) + 1;
    localparam int GW = $clog2(FRAME_CYC + 2) + 1;

    logic [RW-1:0] run;
    logic          last_b;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            last_b <= 1'b0;
            gap    <= '0;
        end else begin
            if (bclk != last_b) begin
                run    <= RW'(1);
                last_b <= bclk;
            end else begin
                run    <= run + 1'b1;
            end
            gap <= req ? GW'(1) : gap + 1'b1;
        end
    end

    // R2: each bclk level lasts DIV_HALF cycles
    p_bclk_half_r2: assert property (@(posedge clk) disable iff (rst)
        (bclk != last_b) |-> (run == RW'(DIV_HALF)));

    p_bclk_no_stretch_r2: assert property (@(posedge clk) disable iff (rst)
        run <= RW'(DIV_HALF));

    // R3, R4: serial lines move only with a falling bit clock
    p_lines_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        !($past(bclk) && !bclk) |-> ($stable(sdata) && $stable(lrclk)));

    // R6: request is a single cycle, aligned to the left start
    p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    p_req_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        req |-> (!lrclk && !bclk && $fell(bclk)));

    p_req_period_r6: assert property (@(posedge clk) disable iff (rst)
        req |-> (gap == GW'(FRAME_CYC)));

endmodule

bind stereo_ser_dac stereo_ser_dac_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .bclk (dac_bclk),
    .lrclk(dac_lrclk),
    .sdata(dac_sdata),
    .req  (smp_req)
);

// File: tb/stereo_ser_dac_test.sv
module stereo_ser_dac_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 4;
    localparam int FRAME_CYC  = 64 * DIV_HALF;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic        dac_bclk, dac_lrclk, dac_sdata, smp_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int since_rst = 0;

    int  edge_viol = 0;
    int  req_viol  = 0;
    bit  pv = 0;
    logic p_b, p_lr, p_sd, p_rq;

    stereo_ser_dac #(.DIV_HALF(DIV_HALF)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .dac_bclk(dac_bclk), .dac_lrclk(dac_lrclk),
        .dac_sdata(dac_sdata), .smp_req(smp_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) since_rst <= rst ? 0 : since_rst + 1;

    // line monitor for R3, R4, R6
    always @(negedge clk) begin
        if (rst) begin
            pv = 0;
        end else begin
            if (pv) begin
                if (!(p_b && !dac_bclk) && ((dac_sdata !== p_sd) || (dac_lrclk !== p_lr)))
                    edge_viol++;
                if (smp_req && (p_rq || !(p_b && !dac_bclk) || dac_lrclk))
                    req_viol++;
            end
            pv = 1;
        end
        p_b = dac_bclk; p_lr = dac_lrclk; p_sd = dac_sdata; p_rq = smp_req;
    end

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_pair(logic [15:0] l, logic [15:0] r);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!smp_req);
    endtask

    // collect 32 bits on bclk rises; call just before a frame's first rise
    task automatic get_frame(output logic [15:0] l, output logic [15:0] r, output int lr_bad);
        int n = 0;
        logic pb = dac_bclk;
        l = '0; r = '0; lr_bad = 0;
        while (n < 32) begin
            @(negedge clk);
            if (!pb && dac_bclk) begin
                if (n < 16) l = {l[14:0], dac_sdata};
                else        r = {r[14:0], dac_sdata};
                if (dac_lrclk !== (n >= 16)) lr_bad++;
                n++;
            end
            pb = dac_bclk;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset outputs", {dac_bclk, dac_lrclk, dac_sdata, smp_req} === 4'b0,
            {dac_bclk, dac_lrclk, dac_sdata, smp_req}, 0);
        rst = 1'b0;
        do @(negedge clk); while (!dac_bclk);
        chk("R2 first rise", since_rst == DIV_HALF, since_rst, DIV_HALF);
        wait_req();
        chk("R6 first request", since_rst == FRAME_CYC, since_rst, FRAME_CYC);
    endtask

    task automatic t_bclk_shape();
        int hi = 0, lo = 0;
        do @(negedge clk); while (!dac_bclk);
        while (dac_bclk) begin hi++; @(negedge clk); end
        while (!dac_bclk) begin lo++; @(negedge clk); end
        chk("R2 high length", hi == DIV_HALF, hi, DIV_HALF);
        chk("R2 low length", lo == DIV_HALF, lo, DIV_HALF);
    endtask

    task automatic t_load_and_flight();
        logic [15:0] l, r; int bad;
        write_pair(16'h1111, 16'h2222);
        wait_req();
        get_frame(l, r, bad);
        wait_req();
        write_pair(16'hA5C3, 16'h1234);
        get_frame(l, r, bad);
        chk("R7 frame in flight unchanged", {l, r} == {16'h1111, 16'h2222}, {l, r}, 32'h11112222);
        chk("R3 lrclk pattern", bad == 0, bad, 0);
        wait_req();
        get_frame(l, r, bad);
        chk("R5 left word", l == 16'hA5C3, l, 16'hA5C3);
        chk("R5 right word", r == 16'h1234, r, 16'h1234);
    endtask

    task automatic t_reuse();
        logic [15:0] l, r; int bad;
        for (int k = 0; k < 2; k++) begin
            wait_req();
            get_frame(l, r, bad);
            chk("R8 pair repeated", {l, r} == {16'hA5C3, 16'h1234}, {l, r}, 32'hA5C31234);
        end
    endtask

    task automatic t_last_wins();
        logic [15:0] l, r; int bad;
        wait_req();
        write_pair(16'h0F0F, 16'hF0F0);
        write_pair(16'h8001, 16'h7FFE);
        get_frame(l, r, bad);
        wait_req();
        get_frame(l, r, bad);
        chk("R7 last write wins", {l, r} == {16'h8001, 16'h7FFE}, {l, r}, 32'h80017FFE);
    endtask

    task automatic t_same_cycle();
        logic [15:0] l, r; int bad;
        wait_req();
        repeat (FRAME_CYC - 1) @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = 16'hC0DE; smp_right = 16'h5A5A;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R6 request at load edge", smp_req === 1'b1, smp_req, 1);
        get_frame(l, r, bad);
        chk("R9 same-cycle write taken", {l, r} == {16'hC0DE, 16'h5A5A}, {l, r}, 32'hC0DE5A5A);
    endtask

    task automatic t_mid_reset();
        logic [15:0] l, r; int bad;
        wait_req();
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mid-frame reset outputs", {dac_bclk, dac_lrclk, dac_sdata, smp_req} === 4'b0,
            {dac_bclk, dac_lrclk, dac_sdata, smp_req}, 0);
        rst = 1'b0;
        get_frame(l, r, bad);
        chk("R10 first frame zero", {l, r} == 32'h0, {l, r}, 0);
        chk("R1 restart at left bit 0", bad == 0, bad, 0);
        wait_req();
        chk("R6 request after restart", since_rst == FRAME_CYC, since_rst, FRAME_CYC);
    endtask

    initial begin
        t_reset();
        t_bclk_shape();
        t_load_and_flight();
        t_reuse();
        t_last_wins();
        t_same_cycle();
        t_mid_reset();
        repeat (20) @(negedge clk);
        chk("R4 data only on falling bclk", edge_viol == 0, edge_viol, 0);
        chk("R6 request shape", req_viol == 0, req_viol, 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule